// File: doc/BRIEF.md
# Receive Burst Traffic Monitor

This block sits on the receive side of an Ethernet datapath and observes a packet stream made of valid, start-of-packet, end-of-packet, empty and error signals. It keeps separate totals for frames that arrive clean and frames that carry an error, and it sums the bytes received. It also times a burst. Software programs how many frames it expects. The block counts clock cycles from the first start of a frame until the frame that completes that total has ended. A done flag then sets and the cycle total holds its value.

Software uses a 32-bit register slave with a one-cycle read latency. It writes the expected frame total, starts a fresh run by writing the clear bit, and polls the done flag. Afterwards it reads the 64-bit byte and cycle totals as two 32-bit halves each. The block does not look at the data bytes. It reads only the framing and sideband signals.

Top module: `rx_burst_monitor`

## Requirements
- R1: After reset, offset 0x00 (expected frame total) reads 0xFFFFFFFF and every other mapped offset reads 0.
- R2: A write to offset 0x00 stores the full 32-bit expected frame total, which then reads back unchanged.
- R3: A beat with valid and end-of-packet high and all error bits low adds one to the clean-frame count at offset 0x04.
- R4: A beat with valid and end-of-packet high and any error bit set adds one to the errored-frame count at offset 0x08. Error bits on beats that are not end-of-packet have no effect.
- R5: Every valid beat adds BEAT_BYTES to the 64-bit byte total. An end-of-packet beat adds BEAT_BYTES minus the empty value instead, and empty is ignored on other beats. The low word reads at 0x0C and the high word at 0x10.
- R6: The 64-bit cycle total (low word at 0x14, high word at 0x18) is 1 on the clock edge of the first start-of-packet beat after a clear or reset. It grows by one on each later edge, up to and including the edge on which the done flag sets, and holds after that.
- R7: Bit 2 of offset 0x1C is the done flag. It sets on the edge of an end-of-packet beat that brings clean plus errored frames equal to the expected total. It stays set until a clear.
- R8: A write to 0x1C with bit 0 set zeroes both frame counts, the byte and cycle totals and the done flag. It leaves the expected total unchanged, and a stream beat in the same cycle is dropped. A write to 0x1C with bit 0 clear changes nothing.
- R9: Read data appears on the cycle after the read strobe. Bits 31:3 and 1:0 of 0x1C read as 0, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Stream beat valid |
| st_sop | input | 1 | First beat of a frame |
| st_eop | input | 1 | Last beat of a frame |
| st_empty | input | EMPTY_W | Unused byte lanes on the last beat |
| st_error | input | ERR_W | Frame error sideband, read on the last beat |
| csr_addr | input | ADDR_W | Register byte offset |
| csr_write | input | 1 | Register write strobe |
| csr_writedata | input | 32 | Register write data |
| csr_read | input | 1 | Register read strobe |
| csr_readdata | output | 32 | Register read data, one cycle after the strobe |

## Verification
Every counter, the done flag and the cycle total change on the clock edge that samples the beat. A register read then needs one more edge to place that value on the read data. The bench drives all inputs on the falling edge. It picks up read data on the falling edge after the read strobe, and compares it with a reference value taken in the cycle the strobe was issued. Because the cycle total keeps counting during a read, that value is taken before the reference model advances for the read cycle. A clear written while a frame end arrives, and a one-beat frame that completes a run of one, are the directed corners.

// File: rtl/rxm_pkg.sv
package rxm_pkg;
  localparam int DATA_W = 32;
  localparam int WIDE_W = 2 * DATA_W;

  localparam logic [7:0] OFF_EXPECT  = 8'h00;
  localparam logic [7:0] OFF_GOOD    = 8'h04;
  localparam logic [7:0] OFF_BAD     = 8'h08;
  localparam logic [7:0] OFF_BYTE_LO = 8'h0C;
  localparam logic [7:0] OFF_BYTE_HI = 8'h10;
  localparam logic [7:0] OFF_CYC_LO  = 8'h14;
  localparam logic [7:0] OFF_CYC_HI  = 8'h18;
  localparam logic [7:0] OFF_CTRL    = 8'h1C;

  localparam int CLR_BIT  = 0;
  localparam int DONE_BIT = 2;

  typedef struct packed {
    logic [DATA_W-1:0] good;
    logic [DATA_W-1:0] bad;
    logic [WIDE_W-1:0] bytes;
    logic [WIDE_W-1:0] cycles;
    logic              done;
  } rxm_stats_t;
endpackage

// File: rtl/rxm_frame_tally.sv
module rxm_frame_tally
  import rxm_pkg::*;
#(
  parameter int BEAT_BYTES = 8,
  parameter int ERR_W      = 6,
  localparam int EMPTY_W   = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               valid,
  input  logic               eop,
  input  logic [EMPTY_W-1:0] empty,
  input  logic [ERR_W-1:0]   error,
  output logic [DATA_W-1:0]  good_cnt,
  output logic [DATA_W-1:0]  bad_cnt,
  output logic [WIDE_W-1:0]  byte_cnt,
  output logic               frame_end,
  output logic [DATA_W-1:0]  frames_next
);
  logic              beat_end;
  logic [WIDE_W-1:0] beat_bytes;

  assign beat_end    = valid & eop;
  assign beat_bytes  = eop ? (WIDE_W'(BEAT_BYTES) - WIDE_W'(empty)) : WIDE_W'(BEAT_BYTES);
  assign frame_end   = beat_end & ~clr;
  assign frames_next = good_cnt + bad_cnt + DATA_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      good_cnt <= '0;
      bad_cnt  <= '0;
      byte_cnt <= '0;
    end else begin
      if (valid) byte_cnt <= byte_cnt + beat_bytes;
      if (beat_end) begin
        if (|error) bad_cnt  <= bad_cnt + DATA_W'(1);
        else        good_cnt <= good_cnt + DATA_W'(1);
      end
    end
  end

  a_r3_good_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (good_cnt == $past(good_cnt) || good_cnt == $past(good_cnt) + DATA_W'(1)));
  a_r4_bad_step: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (bad_cnt == $past(bad_cnt) || bad_cnt == $past(bad_cnt) + DATA_W'(1)));
  a_r5_bytes_grow: assert property (@(posedge clk) disable iff (rst)
    !clr |=> byte_cnt >= $past(byte_cnt));
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> (good_cnt == '0 && bad_cnt == '0 && byte_cnt == '0));
endmodule

// File: rtl/rxm_burst_timer.sv
module rxm_burst_timer
  import rxm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sop_beat,
  input  logic              frame_end,
  input  logic [DATA_W-1:0] frames_next,
  input  logic [DATA_W-1:0] expected,
  output logic [WIDE_W-1:0] cycles,
  output logic              done
);
  logic started;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      started <= 1'b0;
      cycles  <= '0;
      done    <= 1'b0;
    end else begin
      if (!done) begin
        if (started) begin
          cycles <= cycles + WIDE_W'(1);
        end else if (sop_beat) begin
          started <= 1'b1;
          cycles  <= WIDE_W'(1);
        end
      end
      if (frame_end && frames_next == expected) done <= 1'b1;
    end
  end

  a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> $stable(cycles));
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> done);
  a_r8_clear_done: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!done && cycles == '0));
endmodule

// File: rtl/rxm_csr.sv
module rxm_csr
  import rxm_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [DATA_W-1:0] writedata,
  input  logic              read,
  input  rxm_stats_t        stats,
  output logic [DATA_W-1:0] readdata,
  output logic [DATA_W-1:0] expected,
  output logic              clr
);
  logic [DATA_W-1:0] rd_mux;

  assign clr = write && (addr == ADDR_W'(OFF_CTRL)) && writedata[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) expected <= '1;
    else if (write && addr == ADDR_W'(OFF_EXPECT)) expected <= writedata;
  end

  always_comb begin
    rd_mux = '0;
    if      (addr == ADDR_W'(OFF_EXPECT))  rd_mux = expected;
    else if (addr == ADDR_W'(OFF_GOOD))    rd_mux = stats.good;
    else if (addr == ADDR_W'(OFF_BAD))     rd_mux = stats.bad;
    else if (addr == ADDR_W'(OFF_BYTE_LO)) rd_mux = stats.bytes[DATA_W-1:0];
    else if (addr == ADDR_W'(OFF_BYTE_HI)) rd_mux = stats.bytes[WIDE_W-1:DATA_W];
    else if (addr == ADDR_W'(OFF_CYC_LO))  rd_mux = stats.cycles[DATA_W-1:0];
    else if (addr == ADDR_W'(OFF_CYC_HI))  rd_mux = stats.cycles[WIDE_W-1:DATA_W];
    else if (addr == ADDR_W'(OFF_CTRL))    rd_mux = DATA_W'(stats.done) << DONE_BIT;
  end

  always_ff @(posedge clk) begin
    if (rst)       readdata <= '0;
    else if (read) readdata <= rd_mux;
  end

  a_r1_expect_reset: assert property (@(posedge clk) rst |=> expected == '1);
  a_r9_ctrl_reserved: assert property (@(posedge clk) disable iff (rst)
    (read && addr == ADDR_W'(OFF_CTRL)) |=> (readdata[DATA_W-1:DONE_BIT+1] == '0 && readdata[DONE_BIT-1:0] == '0));
  a_r8_expect_kept: assert property (@(posedge clk) disable iff (rst)
    clr |=> $stable(expected));
endmodule

// File: rtl/rx_burst_monitor.sv
module rx_burst_monitor
  import rxm_pkg::*;
#(
  parameter int BEAT_BYTES = 8,
  parameter int ERR_W      = 6,
  parameter int ADDR_W     = 6,
  localparam int EMPTY_W   = (BEAT_BYTES > 1) ? $clog2(BEAT_BYTES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               st_valid,
  input  logic               st_sop,
  input  logic               st_eop,
  input  logic [EMPTY_W-1:0] st_empty,
  input  logic [ERR_W-1:0]   st_error,
  input  logic [ADDR_W-1:0]  csr_addr,
  input  logic               csr_write,
  input  logic [31:0]        csr_writedata,
  input  logic               csr_read,
  output logic [31:0]        csr_readdata
);
  rxm_stats_t        stats;
  logic              clr;
  logic              frame_end;
  logic [DATA_W-1:0] frames_next;
  logic [DATA_W-1:0] expected;

  rxm_frame_tally #(.BEAT_BYTES(BEAT_BYTES), .ERR_W(ERR_W)) i_tally (
    .clk(clk), .rst(rst), .clr(clr),
    .valid(st_valid), .eop(st_eop), .empty(st_empty), .error(st_error),
    .good_cnt(stats.good), .bad_cnt(stats.bad), .byte_cnt(stats.bytes),
    .frame_end(frame_end), .frames_next(frames_next)
  );

  rxm_burst_timer i_timer (
    .clk(clk), .rst(rst), .clr(clr),
    .sop_beat(st_valid & st_sop), .frame_end(frame_end),
    .frames_next(frames_next), .expected(expected),
    .cycles(stats.cycles), .done(stats.done)
  );

  rxm_csr #(.ADDR_W(ADDR_W)) i_csr (
    .clk(clk), .rst(rst), .addr(csr_addr), .write(csr_write),
    .writedata(csr_writedata), .read(csr_read), .stats(stats),
    .readdata(csr_readdata), .expected(expected), .clr(clr)
  );
endmodule

// File: tb/test_rx_burst_monitor.sv
module test_rx_burst_monitor;
  localparam int BB = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        st_valid = 1'b0, st_sop = 1'b0, st_eop = 1'b0;
  logic [2:0]  st_empty = '0;
  logic [5:0]  st_error = '0;
  logic [5:0]  csr_addr = '0;
  logic        csr_write = 1'b0, csr_read = 1'b0;
  logic [31:0] csr_writedata = '0;
  logic [31:0] csr_readdata;

  rx_burst_monitor #(.BEAT_BYTES(BB), .ERR_W(6), .ADDR_W(6)) i_rx_burst_monitor (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_sop(st_sop), .st_eop(st_eop),
    .st_empty(st_empty), .st_error(st_error), .csr_addr(csr_addr),
    .csr_write(csr_write), .csr_writedata(csr_writedata), .csr_read(csr_read),
    .csr_readdata(csr_readdata)
  );

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  // reference model
  logic [31:0] m_exp = 32'hFFFF_FFFF, m_good = 0, m_bad = 0;
  logic [63:0] m_bytes = 0, m_cyc = 0;
  bit m_started = 0, m_done = 0;
  logic [31:0] rd_sample, snap;

  function automatic logic [31:0] model_reg(input logic [5:0] a);
    case (a)
      6'h00: return m_exp;
      6'h04: return m_good;
      6'h08: return m_bad;
      6'h0C: return m_bytes[31:0];
      6'h10: return m_bytes[63:32];
      6'h14: return m_cyc[31:0];
      6'h18: return m_cyc[63:32];
      6'h1C: return {29'd0, m_done, 2'b00};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step(input bit v, input bit sop, input bit eop, input logic [2:0] emp,
                      input logic [5:0] err, input bit wr, input bit rd,
                      input logic [5:0] a, input logic [31:0] wd);
    bit clr, fin;
    @(negedge clk);
    rd_sample = csr_readdata;
    st_valid = v; st_sop = sop; st_eop = eop; st_empty = emp; st_error = err;
    csr_write = wr; csr_read = rd; csr_addr = a; csr_writedata = wd;
    if (rd) snap = model_reg(a);
    clr = wr && a == 6'h1C && wd[0];
    if (clr) begin
      m_good = 0; m_bad = 0; m_bytes = 0; m_cyc = 0; m_started = 0; m_done = 0;
    end else begin
      fin = v && eop && (m_good + m_bad + 1 == m_exp);
      if (!m_done) begin
        if (m_started) m_cyc++;
        else if (v && sop) begin m_started = 1; m_cyc = 1; end
      end
      if (v) m_bytes += eop ? (BB - emp) : BB;
      if (v && eop) begin
        if (|err) m_bad++; else m_good++;
      end
      if (fin) m_done = 1;
    end
    if (wr && a == 6'h00) m_exp = wd;
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0,0,0); endtask
  task automatic wr(input logic [5:0] a, input logic [31:0] d); step(0,0,0,0,0,1,0,a,d); endtask

  task automatic rd_chk(input logic [5:0] a, input string req);
    logic [31:0] e;
    step(0,0,0,0,0,0,1,a,0);
    e = snap;
    idle();
    chk(req, rd_sample, e);
  endtask

  task automatic send_frame(input int nb, input logic [2:0] emp, input logic [5:0] err, input int gapmax);
    for (int b = 0; b < nb; b++) begin
      int g = (gapmax > 0) ? $urandom_range(gapmax) : 0;
      repeat (g) idle();
      step(1, b == 0, b == nb - 1, (b == nb - 1) ? emp : 3'($urandom),
           (b == nb - 1) ? err : 6'd0, 0, 0, 0, 0);
    end
  endtask

  task automatic check_all();
    rd_chk(6'h04, "R3 good count");
    rd_chk(6'h08, "R4 bad count");
    rd_chk(6'h0C, "R5 bytes low");
    rd_chk(6'h10, "R5 bytes high");
    rd_chk(6'h14, "R6 cycles low");
    rd_chk(6'h18, "R6 cycles high");
    rd_chk(6'h1C, "R7 done flag");
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values, R9 unmapped
    rd_chk(6'h00, "R1 expected reset");
    rd_chk(6'h04, "R1 good reset");
    rd_chk(6'h14, "R1 cycles reset");
    rd_chk(6'h1C, "R1 status reset");
    rd_chk(6'h24, "R9 unmapped offset");
    // R2
    wr(6'h00, 32'h0000_0005);
    rd_chk(6'h00, "R2 expected readback");
    // directed run of five frames, mixed errors
    wr(6'h1C, 32'h1);
    send_frame(3, 3'd2, 6'd0, 0);
    send_frame(1, 3'd7, 6'h20, 2);
    send_frame(4, 3'd0, 6'd0, 3);
    send_frame(2, 3'd5, 6'h01, 1);
    repeat (2) idle();
    rd_chk(6'h1C, "R7 not done before target");
    send_frame(5, 3'd1, 6'd0, 2);
    repeat (3) idle();
    check_all();
    // frame after done: counted, timer frozen, flag kept
    send_frame(2, 3'd3, 6'd0, 1);
    repeat (4) idle();
    check_all();
    // R8: write without clear bit changes nothing
    wr(6'h1C, 32'hFFFF_FFFE);
    rd_chk(6'h04, "R8 no-clear write keeps good");
    rd_chk(6'h1C, "R8 no-clear write keeps done");
    // R8: clear zeroes, keeps expected
    wr(6'h1C, 32'h1);
    check_all();
    rd_chk(6'h00, "R8 expected kept");
    // R8: clear in same cycle as frame end drops the beat
    step(1,1,0,0,0,0,0,0,0);
    step(1,0,1,3'd4,0,1,0,6'h1C,32'h1);
    idle();
    rd_chk(6'h0C, "R8 beat with clear dropped bytes");
    rd_chk(6'h04, "R8 beat with clear dropped frame");
    rd_chk(6'h14, "R8 sop in cleared run not timed");
    // corner: run of one single-beat frame gives one cycle
    wr(6'h00, 32'd1);
    wr(6'h1C, 32'h1);
    repeat (2) idle();
    send_frame(1, 3'd6, 6'd0, 0);
    repeat (3) idle();
    rd_chk(6'h14, "R6 single beat cycles");
    rd_chk(6'h1C, "R7 single beat done");
    // random runs
    for (int run = 0; run < 4; run++) begin
      int n = 3 + $urandom_range(6);
      wr(6'h00, 32'(n));
      wr(6'h1C, 32'h1);
      repeat ($urandom_range(3)) idle();
      for (int f = 0; f < n + 2; f++)
        send_frame(1 + $urandom_range(7), 3'($urandom), ($urandom_range(3) == 0) ? 6'($urandom_range(63, 1)) : 6'd0, 3);
      repeat (2) idle();
      check_all();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule